// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single management transactions against one PHY over a two-wire management link: a clock line it generates itself and a bidirectional data line. The management clock comes from the system clock through a divider. Each low phase and each high phase lasts a programmable number of system clocks. The data line is driven through a separate output-enable, so an external pad cell can release it. A user starts a transaction by pulsing `start` with the direction, the 5-bit PHY address, the 5-bit register address and, for writes, the 16-bit data.

Each frame starts with a run of ones for preamble. Next come a start pattern, an opcode, the two addresses and a two-bit turnaround. After that, 16 data bits go either out to the PHY or in from it. On a read the master requires the PHY to pull the second turnaround bit low. If the PHY does not, the master clocks a recovery run with the line released and reports an error instead of data. The end of every transaction is marked by a one-clock `done` pulse, with `err` and `rd_data` valid at the same time.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no transaction is active, `mdc` is low, `mdio_oe` is low, `busy` is low and `done` is low.
- R2: While busy, every `mdc` high phase and every `mdc` low phase lasts exactly HALF_DIV system clocks. A transaction of N bit slots keeps `busy` high for exactly N*2*HALF_DIV clocks.
- R3: The first 32 slots of every transaction drive the data line high with `mdio_oe` set.
- R4: After the preamble the master drives, each bit in its own slot: 0, then 1. It then drives the opcode, which is 1,0 for a read (`rd_nwr`=1) and 0,1 for a write. Next comes the PHY address, most significant bit first, and then the register address, most significant bit first.
- R5: A write then drives turnaround 1,0 and the 16 data bits most significant first. It then releases the line for one more slot, for 65 slots in total.
- R6: A read releases the line from slot 46 onward. The value sampled in slot 47 must be 0. Slots 48 to 63 are captured into `rd_data` most significant bit first, and two released slots follow, for 66 slots in total. `err` is 0 at `done`.
- R7: If the read sample in slot 47 is 1, the master clocks 32 further slots with the line released, for 80 in total. It then raises `done` with `err`=1 and `rd_data`=0.
- R8: `mdio_o` and `mdio_oe` change only in clocks where `mdc` is low. A bit is sampled in the last system clock of a slot's high phase, through a two-flop synchronizer.
- R9: A `start` pulse while `busy` is high is ignored. The frame in flight and its latched address and data are unchanged, and no second transaction follows.
- R10: `done` is high for one clock per transaction, while `busy` is already low. `err` is cleared again by the next successful transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock request pulse, honoured only while idle |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write |
| rd_data | output | 16 | Captured read data, valid with `done` |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Turnaround failure of the last read, valid with `done` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
`done` rises N*2*HALF_DIV clocks after the clock edge that accepts `start`, with N = 65, 66 or 80 slots. The bench therefore counts the clocks in which `busy` is high, sampled at the falling system-clock edge, and compares the count with that product. It does not wait a fixed delay. Each slot's line value and enable are logged at the `mdc` rising edge, where the master holds them stable. The PHY model changes its reply bit at the `mdc` falling edge that opens each slot, which leaves the full HALF_DIV high clocks for the two synchronizer flops before the sample. `rd_data` and `err` are checked in the clock where `done` is seen.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_DIV  = 4,
  parameter int PRE_LEN   = 32,
  parameter int RECOV_LEN = 32,
  parameter int RD_TAIL   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd_nwr,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int SLOT = 2 * HALF_DIV;
  localparam int CW   = $clog2(SLOT);
  localparam int LW   = 6;

  typedef enum logic [2:0] {IDLE, PRE, HDR, TA, RDAT, TAIL, RECOV} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [LW-1:0] left;
  logic [31:0] sr;
  logic [15:0] rsh;
  logic        rd_q, err_q, done_q;
  logic [1:0]  sy;

  wire slot_end = (cnt == CW'(SLOT - 1));
  wire last     = (left == '0);
  wire smp      = sy[1];

  assign busy    = (st != IDLE);
  assign mdc     = (cnt >= CW'(HALF_DIV));
  assign mdio_oe = (st == PRE) || (st == HDR);
  assign mdio_o  = (st == PRE) ? 1'b1 : (st == HDR) ? sr[31] : 1'b0;
  assign rd_data = rsh;
  assign done    = done_q;
  assign err     = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      left   <= '0;
      sr     <= '0;
      rsh    <= '0;
      rd_q   <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      sy     <= '0;
    end else begin
      done_q <= 1'b0;
      sy     <= {sy[0], mdio_i};
      if (st == IDLE) begin
        cnt <= '0;
        if (start) begin
          st    <= PRE;
          left  <= LW'(PRE_LEN - 1);
          rd_q  <= rd_nwr;
          sr    <= {2'b01, (rd_nwr ? 2'b10 : 2'b01), phy_addr, reg_addr, 2'b10, wr_data};
          rsh   <= '0;
          err_q <= 1'b0;
        end
      end else begin
        cnt <= slot_end ? '0 : cnt + CW'(1);
        if (slot_end) begin
          left <= left - LW'(1);
          unique case (st)
            PRE: if (last) begin
              st   <= HDR;
              left <= rd_q ? LW'(13) : LW'(31);
            end
            HDR: begin
              sr <= {sr[30:0], 1'b0};
              if (last) begin
                st   <= rd_q ? TA : TAIL;
                left <= rd_q ? LW'(1) : LW'(0);
              end
            end
            TA: if (last) begin
              st   <= smp ? RECOV : RDAT;
              left <= smp ? LW'(RECOV_LEN - 1) : LW'(15);
            end
            RDAT: begin
              rsh <= {rsh[14:0], smp};
              if (last) begin
                st   <= TAIL;
                left <= LW'(RD_TAIL - 1);
              end
            end
            TAIL: if (last) begin
              st     <= IDLE;
              done_q <= 1'b1;
            end
            RECOV: if (last) begin
              st     <= IDLE;
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end
            default: st <= IDLE;
          endcase
        end
      end
    end
  end
endmodule

module mdio_master_chk #(
  parameter int HALF_DIV = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] rd_data
);
  logic [15:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else        hi_run <= mdc ? hi_run + 16'd1 : 16'd0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  assert_high_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> hi_run == 16'(HALF_DIV));

  assert_change_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> rd_data == 16'h0000);
endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int HD = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_nwr = 1'b0;
  logic [4:0] phy_addr = '0, reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic busy, done, err, mdc, mdio_o, mdio_oe;
  logic phy_drv = 1'b1;
  wire  mdio_i = mdio_oe ? mdio_o : phy_drv;

  mdio_master #(.HALF_DIV(HD)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .busy(busy), .done(done), .err(err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int nslot = 0, nfall = 0, busy_clks = 0, done_clks = 0;
  bit lo [0:127];
  bit loe[0:127];
  bit m_rd, m_bad;
  logic [15:0] m_data;

  always @(posedge mdc) begin
    if (nslot < 128) begin lo[nslot] = mdio_o; loe[nslot] = mdio_oe; end
    nslot++;
  end

  always @(negedge mdc) begin
    nfall++;
    if (m_rd && nfall == 47)                   phy_drv <= m_bad;
    else if (m_rd && nfall >= 48 && nfall <= 63) phy_drv <= m_data[63 - nfall];
    else                                         phy_drv <= 1'b1;
  end

  always @(negedge clk) begin
    if (busy) busy_clks++;
    if (done) done_clks++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  task automatic pulse_start(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd);
    @(negedge clk);
    rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input bit rd, input bit bad, input logic [4:0] pa,
                     input logic [4:0] ra, input logic [15:0] wd, input bit inject);
    logic [63:0] frame;
    int n_exp, e_pre, e_hdr, e_rest, t;
    nslot = 0; nfall = 0; busy_clks = 0; done_clks = 0;
    m_rd = rd; m_bad = bad; m_data = wd;
    pulse_start(rd, pa, ra, wd);
    if (inject) begin
      repeat (100) @(negedge clk);
      pulse_start(!rd, ~pa, ~ra, ~wd);
    end
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    n_exp = !rd ? 65 : (bad ? 80 : 66);
    // R6 R7 R10: results valid with done
    chk(done === 1'b1, "R10 done", done, 1);
    chk(busy === 1'b0, "R10 busy low at done", busy, 0);
    chk(err === (rd && bad), "R6/R7 err", err, rd && bad);
    if (rd) chk(rd_data === (bad ? 16'h0 : wd), bad ? "R7 rd_data" : "R6 rd_data",
                rd_data, bad ? 0 : wd);
    repeat (300) @(negedge clk);
    chk(done_clks == 1, "R10 done width", done_clks, 1);
    chk(busy === 1'b0 && mdc === 1'b0, "R9 no follow-on", busy, 0);
    chk(nslot == n_exp, rd ? (bad ? "R7 slots" : "R6 slots") : "R5 slots", nslot, n_exp);
    chk(busy_clks == n_exp * 2 * HD, "R2 busy clocks", busy_clks, n_exp * 2 * HD);
    frame = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra,
             (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : wd)};
    e_pre = 0; e_hdr = 0; e_rest = 0;
    for (int k = 0; k < n_exp && k < 128; k++) begin
      bit eoe = rd ? (k < 46) : (k < 64);
      if (k < 32) begin
        if (loe[k] != 1'b1 || lo[k] != 1'b1) e_pre++;
      end else if (k < 46) begin
        if (loe[k] != 1'b1 || lo[k] != frame[63-k]) e_hdr++;
      end else begin
        if (loe[k] != eoe || (eoe && lo[k] != frame[63-k])) e_rest++;
      end
    end
    chk(e_pre == 0, "R3 preamble", e_pre, 0);
    chk(e_hdr == 0, "R4 header", e_hdr, 0);
    chk(e_rest == 0, rd ? "R6 released tail" : "R5 turnaround/data", e_rest, 0);
  endtask

  localparam logic [27:0] VEC [6] = '{
    {1'b0, 1'b0, 5'h01, 5'h00, 16'hA5C3},
    {1'b1, 1'b0, 5'h10, 5'h01, 16'h8001},
    {1'b0, 1'b0, 5'h1F, 5'h1F, 16'hFFFF},
    {1'b1, 1'b1, 5'h0A, 5'h15, 16'h1234},
    {1'b1, 1'b0, 5'h00, 5'h1E, 16'h7E5A},
    {1'b0, 1'b0, 5'h00, 5'h00, 16'h0000}
  };

  initial begin
    m_rd = 0; m_bad = 0; m_data = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1 reset lines", {mdc, mdio_oe}, 0);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 reset flags",
        {busy, done, err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mdc === 1'b0 && busy === 1'b0, "R1 idle after reset", {mdc, busy}, 0);

    for (int i = 0; i < 6; i++)
      run(VEC[i][27], VEC[i][26], VEC[i][25:21], VEC[i][20:16], VEC[i][15:0], 1'b0);

    // R9: start while busy is ignored
    run(1'b0, 1'b0, 5'h05, 5'h0C, 16'h3C96, 1'b1);
    run(1'b1, 1'b0, 5'h13, 5'h02, 16'hC001, 1'b1);
    // R7 then R10: error then clean read clears err
    run(1'b1, 1'b1, 5'h1F, 5'h00, 16'hFFFF, 1'b0);
    run(1'b1, 1'b0, 5'h01, 5'h01, 16'h0001, 1'b0);
    chk(err === 1'b0, "R10 err cleared", err, 0);
    // R8: timing and edge placement covered by bound properties; idle line after last run
    chk(mdio_oe === 1'b0, "R8 released when idle", mdio_oe, 0);
    finish_run();
  end
endmodule